// File: doc/BRIEF.md
# Tagged Sequential Next-Block Prefetch Controller

This block sits beside a small direct-mapped cache model and watches the processor's stream of block addresses. Each lookup is answered with hit or miss in the same cycle. A demand miss sends a demand fetch to memory. Selected references also queue a speculative fetch of the next sequential block, so that a stream walking forward through memory finds its next block already loaded. Each line holds a valid bit, a block tag and a one-bit "prefetched, not yet used" marker. Prefetched blocks take their own lines and are evicted on their own, like any other block.

The `mode_tagged` input selects one of two policies. When it is low, only a demand miss launches a next-block prefetch. When it is high, the first reference to a line that arrived by prefetch launches one as well, so a sequential stream keeps running ahead without taking further misses. Memory serves one request at a time. A request is a single-cycle pulse carrying the block address and a demand/prefetch flag, and `fill_valid` returns the data for whichever request is outstanding.

Top module: `nbp_seqpf`

## Requirements
- R1: `cpu_hit` and `cpu_miss` answer the lookup in the same cycle that `cpu_req` is high. A hit means the line at index `cpu_addr[IDX_W-1:0]` is valid and its tag equals `cpu_addr[ADDR_W-1:IDX_W]`. Neither output is high without `cpu_req`.
- R2: A miss on a block that is neither outstanding nor pending makes that block the pending demand. The demand is issued (`mem_req_valid`=1, `mem_req_pf`=0) in the next cycle in which no request is outstanding, at the earliest the cycle after the miss. A newer demand miss replaces a pending demand that has not yet been issued.
- R3: A miss that creates a demand makes block b+1, taken modulo 2^ADDR_W, the pending prefetch. This holds in both modes. A miss on a block that is already outstanding or pending triggers nothing.
- R4: With `mode_tagged`=1, the first hit on a line whose prefetch marker is set triggers a prefetch of b+1 and clears the marker in that cycle. Later hits on the line trigger nothing. With `mode_tagged`=0, hits never trigger a prefetch.
- R5: No prefetch is queued for b+1 when b+1 already hits in the cache.
- R6: After a request is issued, no other request appears until `fill_valid` has been seen. The earliest next request is in the cycle after that fill.
- R7: When a demand and a prefetch are both pending, the demand is issued first.
- R8: A block that is outstanding, or pending as either kind, is never queued a second time.
- R9: A fill writes only the line at the outstanding block's index. It sets the line valid with the new tag, clears the prefetch marker for a demand fill and sets it for a prefetch fill. A fill and a first hit on the same line in one cycle leave the fill's value.
- R10: A newer prefetch candidate replaces a pending prefetch that has not yet been issued.
- R11: After reset every line is invalid, nothing is pending and no request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| mode_tagged | input | 1 | 1: tagged policy, 0: prefetch only on demand miss |
| cpu_req | input | 1 | Processor lookup valid |
| cpu_addr | input | ADDR_W | Processor block address |
| cpu_hit | output | 1 | Lookup hit (same cycle) |
| cpu_miss | output | 1 | Lookup miss (same cycle) |
| mem_req_valid | output | 1 | Memory request pulse |
| mem_req_addr | output | ADDR_W | Requested block address |
| mem_req_pf | output | 1 | 1: prefetch request, 0: demand request |
| fill_valid | input | 1 | Fill return for the outstanding request |

## Verification
The hardest state to reach from the ports has a demand and a prefetch pending together while memory is still busy. A second miss then has to replace the queued prefetch before that prefetch is ever issued. The stimulus gets there by holding fills back with a long latency and sending three misses in three consecutive cycles. It then checks that the displaced block never reaches memory and that both demands go out ahead of the surviving prefetch. The tagged chain is driven by a blocking sequential walk. In that walk, retries against a block still in flight must trigger nothing, so the number of demands and prefetches per mode is a fixed count that can be checked exactly.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  typedef enum logic {
    REQ_DEMAND   = 1'b0,
    REQ_PREFETCH = 1'b1
  } req_kind_e;
endpackage

// File: rtl/nbp_tagstore.sv
module nbp_tagstore #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] look_a_addr,
  input  logic [ADDR_W-1:0] look_b_addr,
  output logic              look_a_hit,
  output logic              look_a_pf,
  output logic              look_b_hit,
  input  logic              pf_clr_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_pf
);
  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0] v_all;
  logic [LINES-1:0] pf_all;
  logic [TAG_W-1:0] tag_all [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic             line_v;
    logic             line_pf;
    logic [TAG_W-1:0] line_tag;
    logic             sel_wr;
    logic             sel_clr;
    logic             v_d;
    logic             pf_d;
    logic             pf_en;

    always_comb begin
      sel_wr  = wr_en && (wr_addr[IDX_W-1:0] == IDX_W'(i));
      sel_clr = pf_clr_en && (look_a_addr[IDX_W-1:0] == IDX_W'(i));
      v_d     = line_v | sel_wr;
      pf_en   = sel_wr | sel_clr;
      pf_d    = sel_wr ? wr_pf : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_v <= 1'b0;
      else        line_v <= v_d;
    end

    always_ff @(posedge clk) begin
      if (sel_wr) line_tag <= wr_addr[ADDR_W-1:IDX_W];
    end

    always_ff @(posedge clk) begin
      if (pf_en) line_pf <= pf_d;
    end

    assign v_all[i]   = line_v;
    assign pf_all[i]  = line_pf;
    assign tag_all[i] = line_tag;
  end

  logic [IDX_W-1:0] idx_a, idx_b;
  always_comb begin
    idx_a      = look_a_addr[IDX_W-1:0];
    idx_b      = look_b_addr[IDX_W-1:0];
    look_a_hit = v_all[idx_a] && (tag_all[idx_a] == look_a_addr[ADDR_W-1:IDX_W]);
    look_a_pf  = pf_all[idx_a];
    look_b_hit = v_all[idx_b] && (tag_all[idx_b] == look_b_addr[ADDR_W-1:IDX_W]);
  end
endmodule

// File: rtl/nbp_trigger.sv
module nbp_trigger #(
  parameter int ADDR_W = 10
) (
  input  logic              mode_tagged,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              look_a_hit,
  input  logic              look_a_pf,
  input  logic              look_b_hit,
  input  logic              dmd_v,
  input  logic [ADDR_W-1:0] dmd_addr,
  input  logic              pf_v,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic              out_v,
  input  logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] next_addr,
  output logic              cpu_hit,
  output logic              cpu_miss,
  output logic              dmd_set,
  output logic              pf_set,
  output logic              pf_clr
);
  logic busy_a, busy_b, first_use, fire;

  always_comb begin
    next_addr = cpu_addr + ADDR_W'(1);
    busy_a    = (out_v && out_addr == cpu_addr) ||
                (dmd_v && dmd_addr == cpu_addr) ||
                (pf_v  && pf_addr  == cpu_addr);
    busy_b    = (out_v && out_addr == next_addr) ||
                (dmd_v && dmd_addr == next_addr) ||
                (pf_v  && pf_addr  == next_addr);
    cpu_hit   = cpu_req && look_a_hit;
    cpu_miss  = cpu_req && !look_a_hit;
    first_use = cpu_hit && look_a_pf;
    pf_clr    = first_use;
    dmd_set   = cpu_miss && !busy_a;
    fire      = dmd_set || (mode_tagged && first_use);
    pf_set    = fire && !look_b_hit && !busy_b;
  end
endmodule

// File: rtl/nbp_reqq.sv
module nbp_reqq
  import nbp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dmd_set,
  input  logic [ADDR_W-1:0] dmd_set_addr,
  input  logic              pf_set,
  input  logic [ADDR_W-1:0] pf_set_addr,
  input  logic              fill_valid,
  output logic              dmd_v,
  output logic [ADDR_W-1:0] dmd_addr,
  output logic              pf_v,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              out_v,
  output logic [ADDR_W-1:0] out_addr,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_pf,
  output logic              fill_we,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              fill_pf
);
  req_kind_e out_kind;
  req_kind_e issue_kind;
  logic      issue;
  logic      dmd_v_d, pf_v_d, out_v_d;

  always_comb begin
    issue      = !out_v && (dmd_v || pf_v);
    issue_kind = dmd_v ? REQ_DEMAND : REQ_PREFETCH;
    dmd_v_d    = dmd_set ? 1'b1 : ((issue && dmd_v) ? 1'b0 : dmd_v);
    pf_v_d     = pf_set  ? 1'b1 : ((issue && !dmd_v) ? 1'b0 : pf_v);
    out_v_d    = out_v ? !fill_valid : issue;
    mem_req_valid = issue;
    mem_req_addr  = dmd_v ? dmd_addr : pf_addr;
    mem_req_pf    = (issue_kind == REQ_PREFETCH);
    fill_we       = out_v && fill_valid;
    fill_addr     = out_addr;
    fill_pf       = (out_kind == REQ_PREFETCH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmd_v <= 1'b0;
      pf_v  <= 1'b0;
      out_v <= 1'b0;
    end else begin
      dmd_v <= dmd_v_d;
      pf_v  <= pf_v_d;
      out_v <= out_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (dmd_set) dmd_addr <= dmd_set_addr;
  end

  always_ff @(posedge clk) begin
    if (pf_set) pf_addr <= pf_set_addr;
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      out_addr <= mem_req_addr;
      out_kind <= issue_kind;
    end
  end
endmodule

// File: rtl/nbp_seqpf.sv
module nbp_seqpf #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_tagged,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_hit,
  output logic              cpu_miss,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              mem_req_pf,
  input  logic              fill_valid
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              look_a_hit, look_a_pf, look_b_hit;
  logic [ADDR_W-1:0] next_addr;
  logic              dmd_v, pf_v, out_v;
  logic [ADDR_W-1:0] dmd_addr, pf_addr, out_addr;
  logic              dmd_set, pf_set, pf_clr;
  logic              fill_we, fill_pf;
  logic [ADDR_W-1:0] fill_addr;

  nbp_tagstore #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .look_a_addr (cpu_addr),
    .look_b_addr (next_addr),
    .look_a_hit  (look_a_hit),
    .look_a_pf   (look_a_pf),
    .look_b_hit  (look_b_hit),
    .pf_clr_en   (pf_clr),
    .wr_en       (fill_we),
    .wr_addr     (fill_addr),
    .wr_pf       (fill_pf)
  );

  nbp_trigger #(.ADDR_W(ADDR_W)) u_trig (
    .mode_tagged (mode_tagged),
    .cpu_req     (cpu_req),
    .cpu_addr    (cpu_addr),
    .look_a_hit  (look_a_hit),
    .look_a_pf   (look_a_pf),
    .look_b_hit  (look_b_hit),
    .dmd_v       (dmd_v),
    .dmd_addr    (dmd_addr),
    .pf_v        (pf_v),
    .pf_addr     (pf_addr),
    .out_v       (out_v),
    .out_addr    (out_addr),
    .next_addr   (next_addr),
    .cpu_hit     (cpu_hit),
    .cpu_miss    (cpu_miss),
    .dmd_set     (dmd_set),
    .pf_set      (pf_set),
    .pf_clr      (pf_clr)
  );

  nbp_reqq #(.ADDR_W(ADDR_W)) u_q (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .dmd_set       (dmd_set),
    .dmd_set_addr  (cpu_addr),
    .pf_set        (pf_set),
    .pf_set_addr   (next_addr),
    .fill_valid    (fill_valid),
    .dmd_v         (dmd_v),
    .dmd_addr      (dmd_addr),
    .pf_v          (pf_v),
    .pf_addr       (pf_addr),
    .out_v         (out_v),
    .out_addr      (out_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_pf    (mem_req_pf),
    .fill_we       (fill_we),
    .fill_addr     (fill_addr),
    .fill_pf       (fill_pf)
  );
endmodule

// File: rtl/nbp_seqpf_chk.sv
module nbp_seqpf_chk (
  input logic clk,
  input logic rst_int_n,
  input logic cpu_req,
  input logic cpu_hit,
  input logic cpu_miss,
  input logic mem_req_valid,
  input logic mem_req_pf,
  input logic fill_valid,
  input logic dmd_v
);
  logic busy;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)         busy <= 1'b0;
    else if (mem_req_valid) busy <= 1'b1;
    else if (fill_valid)    busy <= 1'b0;
  end

  a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(cpu_hit && cpu_miss));

  a_r1_needs_req: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cpu_hit || cpu_miss) |-> cpu_req);

  a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req_valid |-> !busy);

  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_req_valid |=> !mem_req_valid);

  a_r7_demand_first: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mem_req_valid && mem_req_pf) |-> !dmd_v);
endmodule

bind nbp_seqpf nbp_seqpf_chk u_chk (
  .clk           (clk),
  .rst_int_n     (rst_int_n),
  .cpu_req       (cpu_req),
  .cpu_hit       (cpu_hit),
  .cpu_miss      (cpu_miss),
  .mem_req_valid (mem_req_valid),
  .mem_req_pf    (mem_req_pf),
  .fill_valid    (fill_valid),
  .dmd_v         (dmd_v)
);

// File: tb/sim_nbp_seqpf.sv
module sim_nbp_seqpf;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int IW = 3;
  localparam int NB = 1 << AW;
  localparam int NL = 1 << IW;
  localparam int PF_MARK = 100000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode;
  logic          req;
  logic [AW-1:0] addr;
  logic          fill;
  logic          cpu_hit, cpu_miss, mem_req_valid, mem_req_pf;
  logic [AW-1:0] mem_req_addr;

  nbp_seqpf #(.ADDR_W(AW), .IDX_W(IW)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_tagged   (mode),
    .cpu_req       (req),
    .cpu_addr      (addr),
    .cpu_hit       (cpu_hit),
    .cpu_miss      (cpu_miss),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_req_pf    (mem_req_pf),
    .fill_valid    (fill)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state
  int m_tag [NL];
  bit m_v   [NL];
  bit m_pf  [NL];
  int m_out, m_dq, m_pq;
  bit m_out_pf;
  int age, lat;
  bit last_h, dut_hit_s;
  int lg[$];
  int n_dem, n_pf;
  string cur_tag;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit infl(input int x);
    return (m_out == x) || (m_dq == x) || (m_pq == x);
  endfunction

  task automatic model_init();
    for (int i = 0; i < NL; i++) begin m_v[i] = 0; m_pf[i] = 0; m_tag[i] = -1; end
    m_out = -1; m_dq = -1; m_pq = -1; m_out_pf = 0; age = 0;
    lg.delete(); n_dem = 0; n_pf = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 1'b0; addr = '0; fill = 1'b0;
    model_init();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic cyc(input bit r, input int a);
    int ix, c, ci, ia;
    bit h, ms, iss, ipf, newd, newp, pres, trig;
    @(negedge clk);
    req = r; addr = AW'(a);
    fill = (m_out >= 0) && (age >= lat);
    #1;
    ix  = a % NL;
    h   = r && m_v[ix] && (m_tag[ix] == a);
    ms  = r && !h;
    iss = (m_out < 0) && (m_dq >= 0 || m_pq >= 0);
    ia  = (m_dq >= 0) ? m_dq : m_pq;
    ipf = !(m_dq >= 0);
    chk(cpu_hit == h, "R1", cpu_hit, h);
    chk(cpu_miss == ms, "R1", cpu_miss, ms);
    chk(mem_req_valid == iss, cur_tag, mem_req_valid, iss);
    if (iss && mem_req_valid) begin
      chk(int'(mem_req_addr) == ia, cur_tag, mem_req_addr, ia);
      chk(mem_req_pf == ipf, "R7", mem_req_pf, ipf);
    end
    if (mem_req_valid) begin
      lg.push_back(int'(mem_req_addr) + (mem_req_pf ? PF_MARK : 0));
      if (mem_req_pf) n_pf++; else n_dem++;
    end
    last_h = h; dut_hit_s = cpu_hit;
    // next state
    newd = ms && !infl(a);
    c    = (a + 1) % NB;
    ci   = c % NL;
    pres = m_v[ci] && (m_tag[ci] == c);
    trig = newd || (mode && h && m_pf[ix]);
    newp = trig && !pres && !infl(c);
    @(posedge clk);
    if (h && m_pf[ix]) m_pf[ix] = 0;
    if (fill && m_out >= 0) begin
      m_v[m_out % NL] = 1; m_tag[m_out % NL] = m_out; m_pf[m_out % NL] = m_out_pf;
      m_out = -1;
    end else if (m_out >= 0) age++;
    if (iss) begin
      if (m_dq >= 0) m_dq = -1; else m_pq = -1;
      m_out = ia; m_out_pf = ipf; age = 0;
    end
    if (newd) m_dq = a;
    if (newp) m_pq = c;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0);
  endtask

  task automatic acc(input int a);
    for (int k = 0; k < 200; k++) begin
      cyc(1, a);
      if (last_h) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    mode = 1'b0; lat = 3; cur_tag = "R6";
    do_reset();

    // R11: reset state
    @(negedge clk); req = 1'b1; addr = AW'(0); #1;
    chk(cpu_hit == 1'b0, "R11", cpu_hit, 0);
    chk(mem_req_valid == 1'b0, "R11", mem_req_valid, 0);
    req = 1'b0;

    // R2 R3 R4: sequential walk, prefetch only on demand miss
    cur_tag = "R2"; mode = 1'b0; do_reset();
    for (int b = 0; b < 8; b++) acc(b);
    idle(20);
    chk(n_dem == 4, "R2", n_dem, 4);
    chk(n_pf == 4, "R4", n_pf, 4);
    chk(lg.size() > 1 && lg[0] == 0, "R7", lg.size() > 0 ? lg[0] : -1, 0);
    chk(lg.size() > 1 && lg[1] == PF_MARK + 1, "R3", lg.size() > 1 ? lg[1] : -1, PF_MARK + 1);

    // R4: tagged chain
    cur_tag = "R4"; mode = 1'b1; do_reset();
    for (int b = 0; b < 8; b++) acc(b);
    idle(20);
    chk(n_dem == 1, "R4", n_dem, 1);
    chk(n_pf == 8, "R4", n_pf, 8);
    acc(3); idle(10);
    chk(n_pf == 8, "R4", n_pf, 8);

    // R5: next block already present
    cur_tag = "R5"; mode = 1'b0; do_reset();
    acc(4); idle(15); acc(3); idle(15);
    chk(n_pf == 1, "R5", n_pf, 1);
    chk(lg.size() == 3 && lg[2] == 3, "R5", lg.size(), 3);

    // R8 R10: in-flight suppression and pending prefetch replacement
    cur_tag = "R10"; mode = 1'b0; lat = 8; do_reset();
    cyc(1, 40); cyc(1, 41); cyc(1, 60); cyc(1, 60);
    idle(40);
    chk(lg.size() == 3, "R8", lg.size(), 3);
    chk(lg.size() == 3 && lg[0] == 40 && lg[1] == 60, "R8", lg.size() > 1 ? lg[1] : -1, 60);
    chk(lg.size() == 3 && lg[2] == PF_MARK + 61, "R10", lg.size() > 2 ? lg[2] : -1, PF_MARK + 61);

    // R3: wrap at top of address space
    cur_tag = "R3"; lat = 2; do_reset();
    acc(NB - 1); idle(10);
    chk(lg.size() == 2 && lg[1] == PF_MARK, "R3", lg.size() > 1 ? lg[1] : -1, PF_MARK);

    // R9: fill kind sets marker; replacement touches only its line
    cur_tag = "R9"; mode = 1'b1; do_reset();
    acc(100); idle(10); acc(100); idle(5);
    chk(lg.size() == 2, "R9", lg.size(), 2);
    acc(101); idle(10);
    chk(lg.size() == 3 && lg[2] == PF_MARK + 102, "R9", lg.size() > 2 ? lg[2] : -1, PF_MARK + 102);
    acc(109); idle(10);
    cyc(1, 100);
    chk(dut_hit_s == 1'b1, "R9", dut_hit_s, 1);
    cyc(1, 101);
    chk(dut_hit_s == 1'b0, "R9", dut_hit_s, 0);

    // mixed stress in both modes against the model
    cur_tag = "R6";
    for (int ph = 0; ph < 6; ph++) begin
      mode = ph[0]; lat = ph % 4; do_reset();
      for (int k = 0; k < 1500; k++)
        cyc(($urandom_range(0, 3) != 0), $urandom_range(0, 40));
      idle(12);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule